// File: doc/BRIEF.md
# E-ink Waveform Lookup Pixel Engine

This engine turns a stream of pixels into e-paper drive codes. Each pixel brings three values: the grey level now on the panel, the grey level it must reach, and the frame of the update that this pixel has reached. The frame value is kept per pixel by an outside store, so neighbouring pixels can be at different points in their waveform. The engine uses the three values to pick one 2-bit code from a waveform table. Each 32-bit table word packs sixteen codes. The code tells the panel driver to leave the pixel alone, push it toward black, or push it toward white.

Software fills the table through a word-addressed write port. A configuration strobe then selects 16-level or 32-level operation and sets the frame total of the waveform. The table layout depends on the mode. In 16-level mode each frame has 16 words and the low four bits of each level are used. In 32-level mode each frame has 64 words and all five bits are used. The frame limits are parameters, with defaults of 32 frames for 16 levels and 8 frames for 32 levels. A configuration that asks for more frames than the selected mode allows is refused, and an error flag is raised. A code comes out one clock after its pixel, and a valid flag travels with it.

Top module: `wfm_lut_engine`

## Requirements
- R1: In 16-level mode (cfg_mode32 = 0) the table word read is frame*16 + prev[3:0]. The code is taken from bits [2s+1:2s] of that word, where s = next[3:0]. Bit 4 of prev and bit 4 of next have no effect.
- R2: In 32-level mode (cfg_mode32 = 1) the table word read is frame*64 + prev*2 + next[4]. The code is taken from bits [2s+1:2s] of that word, where s = next[3:0].
- R3: Stored codes 00 (hold), 01 (toward black) and 10 (toward white) are output unchanged. A stored 11 is output as 00.
- R4: out_valid is pix_valid delayed by exactly one clock. The code for a pixel appears in that same cycle. out_code is 00 whenever out_valid is 0.
- R5: A pixel whose frame index is greater than or equal to the configured frame total outputs 00, whatever the table holds.
- R6: A cfg_load with cfg_frames at most LIM16 (16-level) or LIM32 (32-level) is accepted. The new mode and frame total apply from the next cycle, and cfg_err clears.
- R7: A cfg_load whose cfg_frames exceeds the limit of the requested mode sets cfg_err. The previous mode and frame total stay in force.
- R8: A word written through the table port at any time is used by lookups from the following cycle on.
- R9: After reset the engine is in 16-level mode with a frame total of 0, so every pixel outputs 00. cfg_err and out_valid are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_addr | input | 9 | Table word address |
| tbl_wr_data | input | 32 | Table word, sixteen 2-bit codes |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_mode32 | input | 1 | 1 selects 32 levels, 0 selects 16 levels |
| cfg_frames | input | 6 | Requested frame total |
| cfg_err | output | 1 | Last configuration load was refused |
| pix_valid | input | 1 | Pixel present |
| pix_prev | input | 5 | Grey level currently shown |
| pix_next | input | 5 | Target grey level |
| pix_frame | input | 6 | This pixel's frame index in the update |
| out_valid | output | 1 | Drive code present |
| out_code | output | 2 | Drive code |

## Verification
The bench targets the edges of the frame window. It uses the last legal frame, the frame equal to the total, and the largest frame index. A design that compared with greater-than instead of greater-or-equal would drive pixels one frame too long. The bench also makes refused loads one over each mode's limit and then checks that lookups still use the old mode and total. A design that latched fields on a refused load would return codes from the wrong layout. A word packing all four code values shows whether a stored 11 is forced to hold and whether the slot order is reversed. Lookups in 16-level mode set the unused fifth bits, and lookups in 32-level mode vary next[4]; a design with a wrong address formula reads the wrong word.

// File: rtl/wfm_pkg.sv
`timescale 1ns/1ps
package wfm_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        DRV_HOLD     = 2'b00,
        DRV_TO_BLACK = 2'b01,
        DRV_TO_WHITE = 2'b10,
        DRV_HOLD_ALT = 2'b11
    } drive_e;

    // A second hold encoding is folded onto the first so downstream sees one value.
    function automatic logic [CODE_W-1:0] drive_normalize(input logic [CODE_W-1:0] raw);
        return (raw == DRV_HOLD_ALT) ? DRV_HOLD : raw;
    endfunction

endpackage

// File: rtl/wfm_cfg.sv
`timescale 1ns/1ps
module wfm_cfg #(
    parameter int FRAME_W = 6,
    parameter int LIM16   = 32,
    parameter int LIM32   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic               cfg_mode32,
    input  logic [FRAME_W-1:0] cfg_frames,
    output logic               mode32_q,
    output logic [FRAME_W-1:0] total_q,
    output logic               err_q
);

    typedef struct packed {
        logic               mode32;
        logic [FRAME_W-1:0] total;
        logic               err;
    } cfg_s;

    cfg_s st_d, st_q;
    logic [FRAME_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = cfg_mode32 ? FRAME_W'(LIM32) : FRAME_W'(LIM16);
        if (cfg_load) begin
            if (cfg_frames > limit) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mode32 = cfg_mode32;
                st_d.total  = cfg_frames;
                st_d.err    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode32_q = st_q.mode32;
    assign total_q  = st_q.total;
    assign err_q    = st_q.err;

endmodule

// File: rtl/wfm_index.sv
`timescale 1ns/1ps
module wfm_index #(
    parameter int PIX_W   = 5,
    parameter int FRAME_W = 6,
    parameter int SLOT_W  = 4,
    parameter int ADDR_W  = 9
) (
    input  logic               mode32,
    input  logic [PIX_W-1:0]   prev,
    input  logic [PIX_W-1:0]   next,
    input  logic [FRAME_W-1:0] frame,
    input  logic [FRAME_W-1:0] total,
    output logic [ADDR_W-1:0]  addr,
    output logic [SLOT_W-1:0]  slot,
    output logic               beyond
);

    localparam int ENT16_W = 2 * (PIX_W - 1);
    localparam int ENT32_W = 2 * PIX_W;
    localparam int SEL16_W = ENT16_W - SLOT_W;
    localparam int SEL32_W = ENT32_W - SLOT_W;
    localparam int F16_W   = ADDR_W - SEL16_W;
    localparam int F32_W   = ADDR_W - SEL32_W;

    logic [ENT16_W-1:0] ent16;
    logic [ENT32_W-1:0] ent32;
    logic [ADDR_W-1:0]  addr16, addr32;

    // Entry = prev * levels + next; word = frame * words_per_frame + entry / codes_per_word.
    always_comb begin
        ent16  = {prev[PIX_W-2:0], next[PIX_W-2:0]};
        ent32  = {prev, next};
        addr16 = {frame[F16_W-1:0], ent16[ENT16_W-1:SLOT_W]};
        addr32 = {frame[F32_W-1:0], ent32[ENT32_W-1:SLOT_W]};
        addr   = mode32 ? addr32 : addr16;
        slot   = mode32 ? ent32[SLOT_W-1:0] : ent16[SLOT_W-1:0];
        beyond = (frame >= total);
    end

endmodule

// File: rtl/wfm_table.sv
`timescale 1ns/1ps
module wfm_table #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/wfm_lut_engine.sv
`timescale 1ns/1ps
module wfm_lut_engine
    import wfm_pkg::*;
#(
    parameter int PIX_W    = 5,
    parameter int WORD_W   = 32,
    parameter int LIM16    = 32,
    parameter int LIM32    = 8,
    localparam int CPW     = WORD_W / CODE_W,
    localparam int SLOT_W  = $clog2(CPW),
    localparam int WPF16   = (1 << (2 * (PIX_W - 1))) / CPW,
    localparam int WPF32   = (1 << (2 * PIX_W)) / CPW,
    localparam int DEPTH16 = LIM16 * WPF16,
    localparam int DEPTH32 = LIM32 * WPF32,
    localparam int DEPTH   = (DEPTH16 > DEPTH32) ? DEPTH16 : DEPTH32,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int FRAME_W = $clog2(((LIM16 > LIM32) ? LIM16 : LIM32) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_wr_en,
    input  logic [ADDR_W-1:0]  tbl_wr_addr,
    input  logic [WORD_W-1:0]  tbl_wr_data,
    input  logic               cfg_load,
    input  logic               cfg_mode32,
    input  logic [FRAME_W-1:0] cfg_frames,
    output logic               cfg_err,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_prev,
    input  logic [PIX_W-1:0]   pix_next,
    input  logic [FRAME_W-1:0] pix_frame,
    output logic               out_valid,
    output logic [CODE_W-1:0]  out_code
);

    typedef struct packed {
        logic              valid;
        logic              hold;
        logic [SLOT_W-1:0] slot;
    } pipe_s;

    logic               cfg_mode32_q;
    logic [FRAME_W-1:0] cfg_total_q;
    logic [ADDR_W-1:0]  rd_addr;
    logic [SLOT_W-1:0]  rd_slot;
    logic               rd_beyond;
    logic [WORD_W-1:0]  rd_word;
    logic [CODE_W-1:0]  slot_code [CPW];
    pipe_s              pipe_d, pipe_q;

    wfm_cfg #(
        .FRAME_W (FRAME_W),
        .LIM16   (LIM16),
        .LIM32   (LIM32)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_mode32 (cfg_mode32),
        .cfg_frames (cfg_frames),
        .mode32_q   (cfg_mode32_q),
        .total_q    (cfg_total_q),
        .err_q      (cfg_err)
    );

    wfm_index #(
        .PIX_W   (PIX_W),
        .FRAME_W (FRAME_W),
        .SLOT_W  (SLOT_W),
        .ADDR_W  (ADDR_W)
    ) u_index (
        .mode32 (cfg_mode32_q),
        .prev   (pix_prev),
        .next   (pix_next),
        .frame  (pix_frame),
        .total  (cfg_total_q),
        .addr   (rd_addr),
        .slot   (rd_slot),
        .beyond (rd_beyond)
    );

    wfm_table #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_en   (pix_valid),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    for (genvar g = 0; g < CPW; g++) begin : g_slot
        assign slot_code[g] = rd_word[g*CODE_W +: CODE_W];
    end

    always_comb begin
        pipe_d.valid = pix_valid;
        pipe_d.hold  = rd_beyond;
        pipe_d.slot  = rd_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    always_comb begin
        out_valid = pipe_q.valid;
        out_code  = DRV_HOLD;
        if (pipe_q.valid && !pipe_q.hold) out_code = drive_normalize(slot_code[pipe_q.slot]);
    end

endmodule

// File: rtl/wfm_lut_checker.sv
`timescale 1ns/1ps
module wfm_lut_checker #(
    parameter int FRAME_W = 6,
    parameter int LIM16   = 32,
    parameter int LIM32   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_load,
    input logic               cfg_mode32,
    input logic [FRAME_W-1:0] cfg_frames,
    input logic               cfg_err,
    input logic               cfg_mode_st,
    input logic [FRAME_W-1:0] cfg_total,
    input logic               pix_valid,
    input logic [FRAME_W-1:0] pix_frame,
    input logic               out_valid,
    input logic [1:0]         out_code
);

    logic over;
    assign over = cfg_frames > (cfg_mode32 ? FRAME_W'(LIM32) : FRAME_W'(LIM16));

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pix_valid) |=> out_valid); // R4
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pix_valid) |=> !out_valid); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_code == 2'b00)); // R4
    AST_NO_ALT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_code != 2'b11); // R3
    AST_BEYOND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pix_valid && (pix_frame >= cfg_total)) |=> (out_code == 2'b00)); // R5
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cfg_load && over) |=> (cfg_err && $stable(cfg_total) && $stable(cfg_mode_st))); // R7
    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cfg_load && !over) |=> (!cfg_err && (cfg_total == $past(cfg_frames)))); // R6

endmodule

bind wfm_lut_engine wfm_lut_checker #(
    .FRAME_W (FRAME_W),
    .LIM16   (LIM16),
    .LIM32   (LIM32)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_mode32  (cfg_mode32),
    .cfg_frames  (cfg_frames),
    .cfg_err     (cfg_err),
    .cfg_mode_st (cfg_mode32_q),
    .cfg_total   (cfg_total_q),
    .pix_valid   (pix_valid),
    .pix_frame   (pix_frame),
    .out_valid   (out_valid),
    .out_code    (out_code)
);

// File: tb/tb_wfm_lut_engine.sv
`timescale 1ns/1ps
module tb_wfm_lut_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [8:0]  tbl_wr_addr = '0;
    logic [31:0] tbl_wr_data = '0;
    logic        cfg_load = 1'b0;
    logic        cfg_mode32 = 1'b0;
    logic [5:0]  cfg_frames = '0;
    logic        cfg_err;
    logic        pix_valid = 1'b0;
    logic [4:0]  pix_prev = '0;
    logic [4:0]  pix_next = '0;
    logic [5:0]  pix_frame = '0;
    logic        out_valid;
    logic [1:0]  out_code;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] ref_mem [512];
    logic        m_mode32 = 1'b0;
    logic [5:0]  m_total = '0;
    logic        m_err = 1'b0;

    always #2 clk = ~clk;

    wfm_lut_engine dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_addr (tbl_wr_addr),
        .tbl_wr_data (tbl_wr_data),
        .cfg_load    (cfg_load),
        .cfg_mode32  (cfg_mode32),
        .cfg_frames  (cfg_frames),
        .cfg_err     (cfg_err),
        .pix_valid   (pix_valid),
        .pix_prev    (pix_prev),
        .pix_next    (pix_next),
        .pix_frame   (pix_frame),
        .out_valid   (out_valid),
        .out_code    (out_code)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic m32, input logic [4:0] p,
                                            input logic [4:0] n, input logic [5:0] f);
        int a;
        int s;
        logic [1:0] c;
        if (f >= m_total) return 2'b00;
        if (m32) a = int'(f) * 64 + int'(p) * 2 + int'(n[4]);
        else     a = int'(f) * 16 + int'(p[3:0]);
        s = int'(n[3:0]);
        c = ref_mem[a][2*s +: 2];
        return (c == 2'b11) ? 2'b00 : c;
    endfunction

    task automatic write_word(input int a, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = 9'(a); tbl_wr_data = d;
        ref_mem[a] = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic do_cfg(input string req, input logic m32, input int frames);
        int lim;
        @(negedge clk);
        cfg_load = 1'b1; cfg_mode32 = m32; cfg_frames = 6'(frames);
        lim = m32 ? 8 : 32;
        if (frames > lim) m_err = 1'b1;
        else begin m_err = 1'b0; m_mode32 = m32; m_total = 6'(frames); end
        @(negedge clk);
        cfg_load = 1'b0;
        check(req, "cfg_err", int'(cfg_err), int'(m_err));
    endtask

    task automatic lookup(input string req, input logic [4:0] p, input logic [4:0] n,
                          input logic [5:0] f);
        logic [1:0] e;
        e = exp_code(m_mode32, p, n, f);
        @(negedge clk);
        pix_valid = 1'b1; pix_prev = p; pix_next = n; pix_frame = f;
        @(negedge clk);
        pix_valid = 1'b0;
        check(req, "out_valid", int'(out_valid), 1);
        check(req, $sformatf("code p=%0d n=%0d f=%0d", p, n, f), int'(out_code), int'(e));
    endtask

    task automatic t_reset();
        check("R9", "cfg_err after reset", int'(cfg_err), 0);
        check("R9", "out_valid after reset", int'(out_valid), 0);
        check("R9", "out_code after reset", int'(out_code), 0);
    endtask

    task automatic t_reset_hold();
        // Table contents are nonzero, but the reset frame total of 0 must force hold.
        @(negedge clk);
        pix_valid = 1'b1; pix_prev = 5'd3; pix_next = 5'd9; pix_frame = 6'd0;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R9", "code with zero total", int'(out_code), 0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            tbl_wr_en = 1'b1; tbl_wr_addr = 9'(a);
            tbl_wr_data = 32'(a) * 32'h9E3779B1 + 32'h01234567;
            ref_mem[a] = tbl_wr_data;
        end
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic t_lookup16();
        do_cfg("R6", 1'b0, 32);
        lookup("R1", 5'd0, 5'd0, 6'd0);
        lookup("R1", 5'd15, 5'd15, 6'd31);
        lookup("R1", 5'd7, 5'd2, 6'd12);
        lookup("R1", 5'h1A, 5'h13, 6'd5);
        lookup("R1", 5'h0A, 5'h03, 6'd5);
        lookup("R1", 5'd1, 5'd14, 6'd20);
    endtask

    task automatic t_codes();
        int a;
        a = 3 * 16 + 7;
        write_word(a, 32'hFFFF_00E4);
        lookup("R3", 5'd7, 5'd0, 6'd3);
        check("R3", "slot0 hold", int'(out_code), 0);
        lookup("R3", 5'd7, 5'd1, 6'd3);
        check("R3", "slot1 black", int'(out_code), 1);
        lookup("R3", 5'd7, 5'd2, 6'd3);
        check("R3", "slot2 white", int'(out_code), 2);
        lookup("R3", 5'd7, 5'd3, 6'd3);
        check("R3", "slot3 stored 11", int'(out_code), 0);
        lookup("R3", 5'd7, 5'd15, 6'd3);
        write_word(a, 32'h4000_0000);
        lookup("R8", 5'd7, 5'd15, 6'd3);
        check("R8", "rewritten slot15", int'(out_code), 1);
    endtask

    task automatic t_beyond();
        do_cfg("R6", 1'b0, 4);
        write_word(4 * 16 + 2, 32'h5555_5555);
        lookup("R5", 5'd2, 5'd6, 6'd3);
        lookup("R5", 5'd2, 5'd6, 6'd4);
        check("R5", "frame equal to total", int'(out_code), 0);
        lookup("R5", 5'd2, 5'd6, 6'd63);
    endtask

    task automatic t_reject();
        do_cfg("R7", 1'b1, 9);
        lookup("R7", 5'd9, 5'd17, 6'd3);
        lookup("R7", 5'd2, 5'd6, 6'd4);
        check("R7", "old total kept", int'(out_code), 0);
        do_cfg("R7", 1'b0, 33);
        lookup("R7", 5'd12, 5'd5, 6'd2);
        do_cfg("R6", 1'b1, 8);
    endtask

    task automatic t_lookup32();
        lookup("R2", 5'd0, 5'd0, 6'd0);
        lookup("R2", 5'd31, 5'd31, 6'd7);
        lookup("R2", 5'd10, 5'd5, 6'd2);
        lookup("R2", 5'd10, 5'd21, 6'd2);
        lookup("R2", 5'd19, 5'd16, 6'd6);
        lookup("R5", 5'd19, 5'd16, 6'd8);
    endtask

    task automatic t_stream();
        logic [1:0] e;
        logic [4:0] p;
        logic [4:0] n;
        logic [5:0] f;
        e = 2'b00;
        for (int i = 0; i <= 24; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R4", "stream valid", int'(out_valid), 1);
                check("R4", $sformatf("stream code %0d", i - 1), int'(out_code), int'(e));
            end
            if (i < 24) begin
                p = 5'((i * 7) % 32);
                n = 5'((i * 13 + 3) % 32);
                f = 6'(i % 9);
                e = exp_code(m_mode32, p, n, f);
                pix_valid = 1'b1; pix_prev = p; pix_next = n; pix_frame = f;
            end else begin
                pix_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R4", "idle valid", int'(out_valid), 0);
        check("R4", "idle code", int'(out_code), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 512; a++) ref_mem[a] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_reset_hold();
        t_lookup16();
        t_codes();
        t_beyond();
        t_reject();
        t_lookup32();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule